// File: doc/BRIEF.md
# Double-Buffered Four-Channel DAC Register Bank

This block holds the register state that sits between a 16-bit register bus and four 12-bit digital-to-analog converter channels. Each channel owns a data register, and a single control register carries a polarity bit and a gain bit for every channel. Writes never reach the converters directly in buffered operation. They land in shadow copies, and two dedicated bus reads move the shadows to the active outputs. A read of one address commits all four data shadows in the same clock. A read of a second address commits the control shadow. The two commits are independent of each other.

A mode register sets two things. Its enable bit forces every code output to mid-scale while it is clear. Its buffered bit, when clear, lets a data write take effect on its channel at once. Channel A is index 0 on every output vector. In the control word, channel A takes the highest polarity bit and the highest gain bit, and the other channels follow it in descending bit order.

Top module: `dac_shadow_bank`

## Requirements
- R1: While reset is asserted and right after it is released, every code output is mid-scale 0x800, every polarity and gain output is 0, and the mode register is 0: disabled and unbuffered.
- R2: While the enable bit (bit 1 of the mode register at offset 0x02) is 0, all four code outputs are 0x800, whatever the active data registers hold.
- R3: With buffered mode on (bit 0 of the mode register is 1), a data write leaves every code output unchanged until the data update read.
- R4: A bus read of offset 0x02 copies all four shadow data registers to the active data registers on the same clock edge. The outputs show the new values from the following cycle.
- R5: With buffered mode off, a data write updates the active value of that channel alone on the next clock edge.
- R6: A write to the control register at offset 0x12 leaves the polarity and gain outputs unchanged until the control update read.
- R7: A bus read of offset 0x12 moves the control shadow to the outputs. Polarity of channel n (A=0 to D=3) comes from control bit 7-n, where 1 means bipolar. Gain of channel n comes from control bit 11-n.
- R8: In the mode register at offset 0x02, bit 1 is the converter enable and bit 0 selects buffered mode.
- R9: The data registers of channels A to D are at offsets 0x14, 0x16, 0x18 and 0x1A. Only write-data bits 11:0 are kept.
- R10: The control update read leaves the code outputs unchanged. The data update read leaves the polarity and gain outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte address of the register access |
| bus_wdata | input | 16 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| dac_code | output | 48 | Four 12-bit codes, channel A in bits 11:0 |
| dac_bipolar | output | 4 | Per-channel polarity, 1 means bipolar, channel A in bit 0 |
| dac_gain | output | 4 | Per-channel gain select, channel A in bit 0 |

## Verification
The bench builds the block with its default four channels of 12 bits. At that size it can sweep every one of the 256 combinations of the eight polarity and gain control bits through the shadow-then-commit path, checking the bit mirroring for each channel. It writes sixteen arithmetic data patterns per channel, from zero through full scale, with junk in the upper write bits. These are checked in buffered mode, in unbuffered mode and while disabled. Both update reads are also checked for leaving the other half of the state untouched.

// File: rtl/dac_shadow_bank.sv
module dac_shadow_bank #(
  parameter int NCH       = 4,
  parameter int DW        = 12,
  parameter int AW        = 6,
  parameter int BUS_W     = 16,
  parameter int MODE_ADDR = 'h02,
  parameter int CTL_ADDR  = 'h12,
  parameter int DATA_BASE = 'h14,
  parameter int POL_TOP   = 7,
  parameter int GAIN_TOP  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [NCH*DW-1:0] dac_code,
  output logic [NCH-1:0]    dac_bipolar,
  output logic [NCH-1:0]    dac_gain
);

  localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

  logic mode_en, mode_buf;
  logic [NCH-1:0] pol_sh, gain_sh;
  logic [NCH*DW-1:0] sh_flat;

  wire data_upd = bus_rd && (bus_addr == AW'(MODE_ADDR));
  wire ctl_upd  = bus_rd && (bus_addr == AW'(CTL_ADDR));
  wire mode_wr  = bus_wr && (bus_addr == AW'(MODE_ADDR));
  wire ctl_wr   = bus_wr && (bus_addr == AW'(CTL_ADDR));
  wire unused_wdata = &{1'b0, bus_wdata[BUS_W-1:GAIN_TOP+1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_en  <= 1'b0;
      mode_buf <= 1'b0;
    end else if (mode_wr) begin
      mode_en  <= bus_wdata[1];
      mode_buf <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_bipolar <= '0;
      dac_gain    <= '0;
    end else if (ctl_upd) begin
      dac_bipolar <= pol_sh;
      dac_gain    <= gain_sh;
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [DW-1:0] sh, act;
    wire hit = bus_wr && (bus_addr == AW'(DATA_BASE + 2*ch));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh         <= '0;
        act        <= '0;
        pol_sh[ch]  <= 1'b0;
        gain_sh[ch] <= 1'b0;
      end else begin
        if (hit) sh <= bus_wdata[DW-1:0];
        if (hit && !mode_buf) act <= bus_wdata[DW-1:0];
        else if (data_upd)    act <= sh;
        if (ctl_wr) begin
          pol_sh[ch]  <= bus_wdata[POL_TOP-ch];
          gain_sh[ch] <= bus_wdata[GAIN_TOP-ch];
        end
      end
    end

    assign sh_flat[ch*DW +: DW]  = sh;
    assign dac_code[ch*DW +: DW] = mode_en ? act : MID;
  end

endmodule

// File: rtl/dac_shadow_bank_chk.sv
module dac_shadow_bank_chk #(
  parameter int NCH       = 4,
  parameter int DW        = 12,
  parameter int AW        = 6,
  parameter int MODE_ADDR = 'h02,
  parameter int CTL_ADDR  = 'h12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [AW-1:0]     bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [NCH*DW-1:0] dac_code,
  input logic [NCH-1:0]    dac_bipolar,
  input logic [NCH-1:0]    dac_gain,
  input logic              mode_en,
  input logic              mode_buf,
  input logic [NCH*DW-1:0] sh_flat,
  input logic [NCH-1:0]    pol_sh,
  input logic [NCH-1:0]    gain_sh
);
  localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};
  wire d_upd = bus_rd && !bus_wr && (bus_addr == AW'(MODE_ADDR));
  wire c_upd = bus_rd && !bus_wr && (bus_addr == AW'(CTL_ADDR));
  wire m_wr  = bus_wr && (bus_addr == AW'(MODE_ADDR));

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dac_bipolar == '0 && dac_gain == '0 && !mode_en && !mode_buf)); // R1
  AST_DISABLED_MID: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |-> dac_code == {NCH{MID}}); // R2
  AST_BUFFERED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_buf && !d_upd && !m_wr) |=> $stable(dac_code)); // R3
  AST_DATA_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (d_upd && mode_en) |=> dac_code == $past(sh_flat)); // R4
  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_addr == AW'(CTL_ADDR)) |=> ($stable(dac_bipolar) && $stable(dac_gain))); // R6
  AST_CTL_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    c_upd |=> (dac_bipolar == $past(pol_sh) && dac_gain == $past(gain_sh))); // R7
  AST_CTL_READ_KEEPS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    c_upd |=> $stable(dac_code)); // R10
endmodule

bind dac_shadow_bank dac_shadow_bank_chk #(
  .NCH(NCH), .DW(DW), .AW(AW), .MODE_ADDR(MODE_ADDR), .CTL_ADDR(CTL_ADDR)
) u_chk (.*);

// File: tb/tb_dac_shadow_bank.sv
module tb_dac_shadow_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int DW  = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic wr = 1'b0, rd = 1'b0;
  wire [NCH*DW-1:0] code;
  wire [NCH-1:0] bip, gain;

  int checks = 0, errors = 0;
  logic [DW-1:0] m_sh[NCH], m_act[NCH];
  logic m_en, m_buf;
  logic [NCH-1:0] m_psh, m_gsh, m_pol, m_gain;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_shadow_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
    .bus_wr(wr), .bus_rd(rd), .dac_code(code), .dac_bipolar(bip), .dac_gain(gain)
  );

  task automatic check(input string tag);
    for (int ch = 0; ch < NCH; ch++) begin
      logic [DW-1:0] e;
      e = m_en ? m_act[ch] : 12'h800;
      checks++;
      if (code[ch*DW +: DW] !== e) begin
        errors++;
        $display("FAIL %s ch%0d code actual %h expected %h", tag, ch, code[ch*DW +: DW], e);
      end
    end
    checks++;
    if (bip !== m_pol || gain !== m_gain) begin
      errors++;
      $display("FAIL %s pol/gain actual %b/%b expected %b/%b", tag, bip, gain, m_pol, m_gain);
    end
  endtask

  task automatic model_reset();
    for (int ch = 0; ch < NCH; ch++) begin m_sh[ch] = '0; m_act[ch] = '0; end
    m_en = 0; m_buf = 0; m_psh = '0; m_gsh = '0; m_pol = '0; m_gain = '0;
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk) addr = a; wdata = d; wr = 1'b1;
    @(negedge clk) wr = 1'b0;
    if (a == 6'h02) begin m_en = d[1]; m_buf = d[0]; end
    if (a == 6'h12)
      for (int ch = 0; ch < NCH; ch++) begin m_psh[ch] = d[7-ch]; m_gsh[ch] = d[11-ch]; end
    if (a >= 6'h14 && a <= 6'h1A && !a[0]) begin
      m_sh[(a-6'h14)/2] = d[11:0];
      if (!m_buf) m_act[(a-6'h14)/2] = d[11:0];
    end
  endtask

  task automatic bus_read(input logic [5:0] a);
    @(negedge clk) addr = a; rd = 1'b1;
    @(negedge clk) rd = 1'b0;
    if (a == 6'h02) for (int ch = 0; ch < NCH; ch++) m_act[ch] = m_sh[ch];
    if (a == 6'h12) begin m_pol = m_psh; m_gain = m_gsh; end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    model_reset();
    @(negedge clk) check("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk) check("R1 after reset");
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    errors++;
    $display("FAIL R1 watchdog actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_n = 1'b1;
    @(negedge clk) check("R1 released");

    bus_write(6'h02, 16'hFFF3);
    check("R8 enable buffered");

    for (int v = 0; v < 16; v++) begin
      for (int ch = 0; ch < NCH; ch++) begin
        bus_write(6'(8'h14 + 2*ch), {4'hA, 12'((v*12'h111 + ch*12'h35) & 12'hFFF)});
        check("R3 buffered hold R9");
      end
      bus_read(6'h12);
      check("R10 ctl read keeps codes");
      bus_read(6'h02);
      check("R4 data commit R9");
    end

    for (int k = 0; k < 256; k++) begin
      bus_write(6'h12, 16'(k << 4) | 16'hF00F);
      check("R6 ctl hold");
      if (k % 32 == 0) begin
        bus_read(6'h02);
        check("R10 data read keeps ctl");
      end
      bus_read(6'h12);
      check("R7 ctl mirror");
    end

    bus_write(6'h02, 16'h0002);
    check("R8 unbuffered");
    for (int ch = 0; ch < NCH; ch++) begin
      bus_write(6'(8'h14 + 2*ch), 16'(12'h9C3 ^ (ch*12'h246)));
      check("R5 immediate update");
    end
    bus_write(6'h1B, 16'h0FFF);
    check("R9 odd address ignored");

    bus_write(6'h02, 16'h0000);
    check("R2 disabled mid-scale");
    bus_write(6'h16, 16'h0123);
    check("R2 disabled write");
    bus_write(6'h02, 16'h0002);
    check("R2 re-enabled shows data");

    do_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule